// File: doc/BRIEF.md
# PN Code Sub-Correlator Bank

This block is the front end of a pseudo-noise code acquisition receiver. It holds a window of received 8-bit samples, one per tap, beside a chain of 1-bit code chips, and splits the full matched-filter correlation into a set of small, independent partial correlations. Each partial correlation, called a sensor, covers a contiguous group of taps. A fusion stage placed after the block combines the partial results robustly. The default configuration has 256 taps in 64 groups of 4.

A single control input selects the mode. While it is high, one code chip from the serial code input and one sample from the serial data input enter the head of their chains each cycle. While it is low, the samples stay where they are and the code chain rotates one position per cycle, so the code slides past the stored samples. Only single-bit code taps move in this mode, which avoids toggling the wide sample registers. The last tap of each chain drives a serial output, so several banks can be chained.

Every cycle each sensor registers the signed sum of its samples. A code chip of 1 adds the sample and a chip of 0 subtracts it.

Top module: `pnc_sensor_bank`

## Requirements
- R1: A synchronous active-high reset clears every code tap, every sample tap and every sensor output to zero at the next clock edge.
- R2: While `load_en` is high, each clock edge moves both chains one tap toward the far end (tap k takes tap k-1). Tap 0 takes `pn_in` in the code chain and `data_in` in the sample chain.
- R3: While `load_en` is low, each clock edge rotates the code chain one tap (tap k takes tap k-1, and tap 0 takes the last tap). All sample taps keep their values.
- R4: `pn_out` always equals the last code tap and `data_out` always equals the last sample tap. A chip or sample loaded at edge n therefore appears on its output after edge n+255 with the default 256 taps.
- R5: Samples are 8-bit two's complement. A code chip of 1 weighs its tap's sample by +1 and a chip of 0 weighs it by -1.
- R6: Sensor s sums the weighted samples of taps 4s to 4s+3. Its result is an 11-bit two's complement value on `sensor_o[11s+10:11s]`.
- R7: Each sensor output is registered. After a clock edge it shows the sum for the tap contents that were present just before that edge.
- R8: The sum of all sensor outputs equals the full correlation over all 256 taps of the same tap contents.
- R9: The extreme sums do not wrap. All samples at -128 give +512 per sensor with all chips 0 and -512 with all chips 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | 1: shift both chains in serially; 0: rotate the code chain and hold the samples |
| pn_in | input | 1 | Serial code chip entering code tap 0 |
| data_in | input | 8 | Serial sample entering sample tap 0 |
| pn_out | output | 1 | Last code tap, for chaining |
| data_out | output | 8 | Last sample tap, for chaining |
| sensor_o | output | 704 | 64 registered signed 11-bit partial correlations; sensor s at bits [11s+10:11s] |

## Verification
The checker assumes that `load_en`, `pn_in` and `data_in` have known values at every clock edge once reset has been applied. It also assumes that reset is held for at least one edge before anything else is checked. The bench drives all inputs on the falling edge with determinate values and holds reset for the first edges, so the shift, rotation and hold properties only see settled inputs. The samples cover the whole two's complement range, including -128, because the range property on each sensor depends on that value being the worst case.

// File: rtl/pnc_pkg.sv
package pnc_pkg;
  localparam int unsigned PNC_TAPS_DEF       = 256;
  localparam int unsigned PNC_TAPS_PER_SENS  = 4;
  localparam int unsigned PNC_SAMPLE_W_DEF   = 8;

  // Width of a signed sum of n terms, each of magnitude up to 2**(w-1).
  function automatic int unsigned pnc_sum_width(input int unsigned w,
                                                input int unsigned n);
    return w + $clog2(n) + 1;
  endfunction
endpackage

// File: rtl/pnc_code_chain.sv
module pnc_code_chain #(
  parameter int unsigned NUM_TAPS = 256
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_en,
  input  logic                pn_in,
  output logic [NUM_TAPS-1:0] taps_o
);
  logic [NUM_TAPS-1:0] chips_q;

  // Only one-bit registers move during the search (rotate) mode.
  always_ff @(posedge clk) begin
    if (rst) begin
      chips_q <= '0;
    end else if (load_en) begin
      chips_q <= {chips_q[NUM_TAPS-2:0], pn_in};
    end else begin
      chips_q <= {chips_q[NUM_TAPS-2:0], chips_q[NUM_TAPS-1]};
    end
  end

  assign taps_o = chips_q;
endmodule

// File: rtl/pnc_data_chain.sv
module pnc_data_chain #(
  parameter int unsigned NUM_TAPS = 256,
  parameter int unsigned SAMPLE_W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         load_en,
  input  logic [SAMPLE_W-1:0]          data_in,
  output logic [NUM_TAPS*SAMPLE_W-1:0] taps_o
);
  localparam int unsigned FLAT_W = NUM_TAPS * SAMPLE_W;

  logic [FLAT_W-1:0] win_q;

  // Samples are written only during a load; otherwise they stay still.
  always_ff @(posedge clk) begin
    if (rst) begin
      win_q <= '0;
    end else if (load_en) begin
      win_q <= {win_q[FLAT_W-SAMPLE_W-1:0], data_in};
    end
  end

  assign taps_o = win_q;
endmodule

// File: rtl/pnc_sensor.sv
module pnc_sensor #(
  parameter int unsigned TAPS     = 4,
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned SUM_W    = 11
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [TAPS-1:0]          chip_i,
  input  logic [TAPS*SAMPLE_W-1:0] samp_i,
  output logic [SUM_W-1:0]         sum_o
);
  localparam int unsigned EXT_W = SUM_W - SAMPLE_W;

  logic signed [SUM_W-1:0] acc;
  logic signed [SUM_W-1:0] term;
  logic signed [SUM_W-1:0] sum_q;

  always_comb begin
    acc  = '0;
    term = '0;
    for (int t = 0; t < int'(TAPS); t++) begin
      term = {{EXT_W{samp_i[t*SAMPLE_W+SAMPLE_W-1]}}, samp_i[t*SAMPLE_W +: SAMPLE_W]};
      acc  = chip_i[t] ? (acc + term) : (acc - term);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q <= '0;
    end else begin
      sum_q <= acc;
    end
  end

  assign sum_o = sum_q;
endmodule

// File: rtl/pnc_sensor_bank.sv
module pnc_sensor_bank #(
  parameter int unsigned NUM_TAPS        = pnc_pkg::PNC_TAPS_DEF,
  parameter int unsigned TAPS_PER_SENSOR = pnc_pkg::PNC_TAPS_PER_SENS,
  parameter int unsigned SAMPLE_W        = pnc_pkg::PNC_SAMPLE_W_DEF,
  localparam int unsigned NUM_SENSORS    = NUM_TAPS / TAPS_PER_SENSOR,
  localparam int unsigned SUM_W          = pnc_pkg::pnc_sum_width(SAMPLE_W, TAPS_PER_SENSOR)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         load_en,
  input  logic                         pn_in,
  input  logic [SAMPLE_W-1:0]          data_in,
  output logic                         pn_out,
  output logic [SAMPLE_W-1:0]          data_out,
  output logic [NUM_SENSORS*SUM_W-1:0] sensor_o
);
  localparam int unsigned GRP_W = TAPS_PER_SENSOR * SAMPLE_W;

  logic [NUM_TAPS-1:0]          code_taps;
  logic [NUM_TAPS*SAMPLE_W-1:0] data_taps;

  pnc_code_chain #(
    .NUM_TAPS (NUM_TAPS)
  ) u_code (
    .clk     (clk),
    .rst     (rst),
    .load_en (load_en),
    .pn_in   (pn_in),
    .taps_o  (code_taps)
  );

  pnc_data_chain #(
    .NUM_TAPS (NUM_TAPS),
    .SAMPLE_W (SAMPLE_W)
  ) u_data (
    .clk     (clk),
    .rst     (rst),
    .load_en (load_en),
    .data_in (data_in),
    .taps_o  (data_taps)
  );

  for (genvar s = 0; s < int'(NUM_SENSORS); s++) begin : g_sensor
    pnc_sensor #(
      .TAPS     (TAPS_PER_SENSOR),
      .SAMPLE_W (SAMPLE_W),
      .SUM_W    (SUM_W)
    ) u_sensor (
      .clk    (clk),
      .rst    (rst),
      .chip_i (code_taps[s*TAPS_PER_SENSOR +: TAPS_PER_SENSOR]),
      .samp_i (data_taps[s*GRP_W +: GRP_W]),
      .sum_o  (sensor_o[s*SUM_W +: SUM_W])
    );
  end

  assign pn_out   = code_taps[NUM_TAPS-1];
  assign data_out = data_taps[NUM_TAPS*SAMPLE_W-1 -: SAMPLE_W];
endmodule

// File: rtl/pnc_sensor_bank_chk.sv
module pnc_sensor_bank_chk #(
  parameter int unsigned NUM_TAPS    = 256,
  parameter int unsigned SAMPLE_W    = 8,
  parameter int unsigned TAPS_PER    = 4,
  parameter int unsigned NUM_SENSORS = 64,
  parameter int unsigned SUM_W       = 11
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         load_en,
  input logic                         pn_in,
  input logic [SAMPLE_W-1:0]          data_in,
  input logic [NUM_TAPS-1:0]          code_taps,
  input logic [NUM_TAPS*SAMPLE_W-1:0] data_taps,
  input logic [NUM_SENSORS*SUM_W-1:0] sensor_o
);
  localparam int MAX_MAG = int'(TAPS_PER) * (2 ** (SAMPLE_W - 1));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (code_taps == '0 && data_taps == '0 && sensor_o == '0));

  // R2
  load_shift_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (code_taps[0] == $past(pn_in) &&
                 data_taps[SAMPLE_W-1:0] == $past(data_in) &&
                 code_taps[NUM_TAPS-1:1] == $past(code_taps[NUM_TAPS-2:0])));

  // R3
  rotate_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> (code_taps[0] == $past(code_taps[NUM_TAPS-1]) && $stable(data_taps)));

  for (genvar s = 0; s < int'(NUM_SENSORS); s++) begin : g_rng
    // R9
    sensor_range_chk: assert property (@(posedge clk) disable iff (rst)
      ($signed(sensor_o[s*SUM_W +: SUM_W]) >= -MAX_MAG &&
       $signed(sensor_o[s*SUM_W +: SUM_W]) <=  MAX_MAG));
  end
endmodule

bind pnc_sensor_bank pnc_sensor_bank_chk #(
  .NUM_TAPS    (NUM_TAPS),
  .SAMPLE_W    (SAMPLE_W),
  .TAPS_PER    (TAPS_PER_SENSOR),
  .NUM_SENSORS (NUM_SENSORS),
  .SUM_W       (SUM_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .load_en   (load_en),
  .pn_in     (pn_in),
  .data_in   (data_in),
  .code_taps (code_taps),
  .data_taps (data_taps),
  .sensor_o  (sensor_o)
);

// File: tb/pnc_sensor_bank_bench.sv
module pnc_sensor_bank_bench;
  localparam int N  = 256;
  localparam int G  = 4;
  localparam int W  = 8;
  localparam int NS = N / G;
  localparam int OW = 11;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              load_en = 1'b0;
  logic              pn_in = 1'b0;
  logic [W-1:0]      data_in = '0;
  logic              pn_out;
  logic [W-1:0]      data_out;
  logic [NS*OW-1:0]  sensor_o;

  pnc_sensor_bank u_pnc_sensor_bank (
    .clk (clk), .rst (rst), .load_en (load_en), .pn_in (pn_in),
    .data_in (data_in), .pn_out (pn_out), .data_out (data_out),
    .sensor_o (sensor_o)
  );

  always #4 clk = ~clk;

  // Behavioural reference: plain arrays of chips (+1/-1) and integer samples.
  int     m_chip [N];
  int     m_samp [N];
  int     exp_sens [NS];
  int     exp_full;
  int     exp_pn, exp_dout;
  int     checks = 0, fails = 0;
  bit     chk_en = 0;
  string  tag = "R1";

  initial begin
    for (int k = 0; k < N; k++) begin m_chip[k] = -1; m_samp[k] = 0; end
  end

  always @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NS; s++) exp_sens[s] = 0;
      for (int k = 0; k < N; k++) begin m_chip[k] = -1; m_samp[k] = 0; end
    end else begin
      for (int s = 0; s < NS; s++) begin
        exp_sens[s] = 0;
        for (int j = 0; j < G; j++) exp_sens[s] += m_chip[G*s+j] * m_samp[G*s+j];
      end
      if (load_en) begin
        for (int k = N-1; k > 0; k--) begin m_chip[k] = m_chip[k-1]; m_samp[k] = m_samp[k-1]; end
        m_chip[0] = pn_in ? 1 : -1;
        m_samp[0] = int'($signed(data_in));
      end else begin
        int last;
        last = m_chip[N-1];
        for (int k = N-1; k > 0; k--) m_chip[k] = m_chip[k-1];
        m_chip[0] = last;
      end
    end
    exp_full = 0;
    for (int s = 0; s < NS; s++) exp_full += exp_sens[s];
    exp_pn   = (m_chip[N-1] > 0) ? 1 : 0;
    exp_dout = m_samp[N-1];
  end

  task automatic compare_all();
    int got, tot;
    tot = 0;
    for (int s = 0; s < NS; s++) begin
      got = int'($signed(sensor_o[s*OW +: OW]));
      tot += got;
      checks++;
      if (got != exp_sens[s]) begin
        fails++;
        $display("FAIL %s/R6/R7 sensor %0d got %0d exp %0d", tag, s, got, exp_sens[s]);
      end
    end
    checks++;
    if (tot != exp_full) begin
      fails++;
      $display("FAIL R8 sensor total got %0d exp %0d", tot, exp_full);
    end
    checks++;
    if (int'(pn_out) != exp_pn) begin
      fails++;
      $display("FAIL R4 pn_out got %0d exp %0d", pn_out, exp_pn);
    end
    checks++;
    if (int'($signed(data_out)) != exp_dout) begin
      fails++;
      $display("FAIL R4 data_out got %0d exp %0d", $signed(data_out), exp_dout);
    end
  endtask

  // Check outputs of the previous edge, then drive the next inputs.
  task automatic cyc(input bit r, input bit le, input bit pn, input logic [W-1:0] d);
    @(negedge clk);
    if (chk_en) compare_all();
    rst = r; load_en = le; pn_in = pn; data_in = d;
  endtask

  bit done = 0;
  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired got running exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    chk_en = 1;
    tag = "R1";
    cyc(1, 1, 1, 8'h55);
    cyc(0, 1, 1, 8'h55);
    // R2 R5: random serial load of a full window
    tag = "R2/R5";
    for (int k = 0; k < N + 4; k++) cyc(0, 1, 1'($urandom), W'($urandom));
    // R3: code slides past held samples, wrap covered by > N cycles
    tag = "R3";
    for (int k = 0; k < N + 40; k++) cyc(0, 0, 1'($urandom), W'($urandom));
    // R2 again: partial reload after rotation, interleaved with rotation
    tag = "R2";
    for (int k = 0; k < 100; k++) cyc(0, (k % 3) != 0, 1'($urandom), W'($urandom));
    // R9: all samples -128 with all chips 0, then all chips 1
    tag = "R9";
    for (int k = 0; k < N + 2; k++) cyc(0, 1, 1'b0, 8'h80);
    cyc(0, 0, 1'b0, 8'h00);
    for (int k = 0; k < N + 2; k++) cyc(0, 1, 1'b1, 8'h80);
    cyc(0, 0, 1'b0, 8'h00);
    // R5: maximum positive samples with alternating chips
    tag = "R5";
    for (int k = 0; k < N + 2; k++) cyc(0, 1, 1'(k % 2), 8'h7f);
    for (int k = 0; k < 8; k++) cyc(0, 0, 1'b0, 8'h00);
    // R1: reset in mid operation clears everything
    tag = "R1";
    cyc(1, 1, 1, 8'h33);
    cyc(0, 0, 0, 8'h00);
    cyc(0, 0, 0, 8'h00);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule